// File: doc/BRIEF.md
# K2 Architecture and Mode Mismatch Monitor

This block watches the received K2 byte of a line carrying linear protection signalling. It checks whether the far end's protection architecture and direction agree with how this end is set up. This end runs a 1+1 architecture. A configuration flag says whether it runs bidirectional or unidirectional. When the far end reports a 1:N architecture, the block declares a mode-mismatch defect. It also declares the defect when this end is bidirectional and the far end reports unidirectional operation.

A K2 value is used only after the same byte has arrived in three consecutive frames. The defect feeds a frame-counted integrator. The integrator raises an alarm once the defect has lasted for the raise window. It drops the alarm once the defect has been absent for the clear window. While the alarm is up, the effective-mode output reports unidirectional operation. The configured mode is reported again when the alarm clears.

The surrounding logic supplies a strobe once per received frame, together with that frame's K2 byte. The default window lengths assume an 8 kHz frame rate: 20000 frames to raise and 80000 frames to clear. Protection switching itself is done elsewhere.

Top module: `k2_mode_monitor`

## Requirements
- R1: After a synchronous reset, mm_defect and mm_alarm are 0 and eff_bidir equals cfg_bidir.
- R2: A K2 byte takes effect only after it has been received in three consecutive frame strobes. A sequence with no three identical bytes in a row leaves the defect unchanged.
- R3: The accepted K2 is decoded as follows. Bit 3 set (1:N architecture) gives a defect. Bits 2:0 equal to 100 (unidirectional) give a defect when cfg_bidir is 1. Bits 2:0 equal to 101 with bit 3 clear (1+1 bidirectional) give no defect. mm_defect follows two clock cycles after the strobe that accepts the byte, which is far inside 100 ms.
- R4: When cfg_bidir is 0, a unidirectional K2 gives no defect, and a 1:N K2 still gives a defect.
- R5: An accepted K2 whose bits 2:0 are neither 100 nor 101 leaves the far-end judgement, and therefore the defect, unchanged. So while the alarm is up, clearing starts only once the far end reports 101.
- R6: mm_alarm rises on the RAISE_FRAMES-th consecutive frame strobe seen with mm_defect high. A strobe seen with mm_defect low restarts that count.
- R7: mm_alarm falls on the CLEAR_FRAMES-th consecutive frame strobe seen with mm_defect low. A strobe seen with mm_defect high restarts that count.
- R8: eff_bidir is 0 while mm_alarm is 1, and it returns to cfg_bidir when the alarm clears.
- R9: mm_alarm changes only in the cycle after a frame strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-cycle strobe per received frame |
| k2_rx | input | 8 | K2 byte of the frame marked by frame_tick |
| cfg_bidir | input | 1 | 1: this end is set to 1+1 bidirectional; 0: 1+1 unidirectional |
| mm_defect | output | 1 | Mode-mismatch defect |
| mm_alarm | output | 1 | Integrated mode-mismatch alarm |
| eff_bidir | output | 1 | Effective mode: 1 bidirectional, 0 unidirectional |

## Verification
Several K2 patterns are fed to the decoder, each separating one behaviour from another:
- Clean 1+1 bidirectional bytes.
- A 1:N byte sent only twice and then a third time, which separates the acceptance rule from plain decoding.
- Two alternating bytes, which show that inconsistent input is ignored.
- Unidirectional bytes under both configuration settings, which separate the architecture check from the direction check.
- A byte with an undefined mode code, which must hold the previous judgement.

The integrator is then driven to one strobe before and exactly at its raise and clear limits. An interrupted run is placed before each limit, so a count that fails to restart would be caught.

// File: rtl/k2mm_pkg.sv
package k2mm_pkg;

  localparam int K2_W = 8;

  // direction codes carried in K2 bits 2:0
  localparam logic [2:0] DIR_BIDIR  = 3'b101;
  localparam logic [2:0] DIR_UNIDIR = 3'b100;
  localparam int ARCH_BIT = 3;

  typedef struct packed {
    logic arch_1n;     // far end runs 1:N
    logic far_unidir;  // far end runs unidirectional
  } far_mode_t;

  function automatic logic is_dir_code(input logic [K2_W-1:0] b);
    return (b[2:0] == DIR_BIDIR) || (b[2:0] == DIR_UNIDIR);
  endfunction

endpackage

// File: rtl/k2_accept_filter.sv
module k2_accept_filter #(
  parameter int W      = 8,
  parameter int REPEAT = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         frame_tick,
  input  logic [W-1:0] k2_in,
  output logic         acc_stb,
  output logic [W-1:0] acc_k2
);
  localparam int CW = (REPEAT > 2) ? $clog2(REPEAT) : 1;
  localparam logic [CW-1:0] RUN_TOP = CW'(REPEAT - 1);
  localparam logic [CW-1:0] RUN_ARM = CW'(REPEAT - 2);

  logic [W-1:0]  last_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q  <= '0;
      run_q   <= '0;
      acc_stb <= 1'b0;
      acc_k2  <= '0;
    end else begin
      acc_stb <= 1'b0;
      if (frame_tick) begin
        if (k2_in != last_q) begin
          last_q <= k2_in;
          run_q  <= '0;
        end else if (run_q != RUN_TOP) begin
          run_q <= run_q + 1'b1;
          if (run_q == RUN_ARM) begin
            acc_stb <= 1'b1;
            acc_k2  <= k2_in;
          end
        end
      end
    end
  end
endmodule

// File: rtl/k2_far_mode_decode.sv
module k2_far_mode_decode
  import k2mm_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            acc_stb,
  input  logic [K2_W-1:0] acc_k2,
  input  logic            cfg_bidir,
  output far_mode_t       far_mode,
  output logic            mismatch
);
  always_ff @(posedge clk) begin
    if (rst) begin
      far_mode <= '0;
    end else if (acc_stb && is_dir_code(acc_k2)) begin
      far_mode.arch_1n    <= acc_k2[ARCH_BIT];
      far_mode.far_unidir <= (acc_k2[2:0] == DIR_UNIDIR);
    end
  end

  always_comb begin
    mismatch = far_mode.arch_1n | (cfg_bidir & far_mode.far_unidir);
  end
endmodule

// File: rtl/mm_alarm_integrator.sv
module mm_alarm_integrator #(
  parameter int RAISE_FRAMES = 20000,
  parameter int CLEAR_FRAMES = 80000
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_tick,
  input  logic mismatch,
  input  logic cfg_bidir,
  output logic mm_defect,
  output logic mm_alarm,
  output logic eff_bidir
);
  localparam int MAXW = (RAISE_FRAMES > CLEAR_FRAMES) ? RAISE_FRAMES : CLEAR_FRAMES;
  localparam int CW   = $clog2(MAXW + 1);
  localparam logic [CW-1:0] RAISE_LAST = CW'(RAISE_FRAMES - 1);
  localparam logic [CW-1:0] CLEAR_LAST = CW'(CLEAR_FRAMES - 1);

  logic [CW-1:0] cnt_q;
  logic          alarm_nxt;

  always_comb begin
    alarm_nxt = mm_alarm;
    if (frame_tick) begin
      if (!mm_alarm && mm_defect && cnt_q == RAISE_LAST) alarm_nxt = 1'b1;
      if (mm_alarm && !mm_defect && cnt_q == CLEAR_LAST) alarm_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mm_defect <= 1'b0;
      mm_alarm  <= 1'b0;
      eff_bidir <= cfg_bidir;
      cnt_q     <= '0;
    end else begin
      mm_defect <= mismatch;
      mm_alarm  <= alarm_nxt;
      eff_bidir <= cfg_bidir & ~alarm_nxt;
      if (frame_tick) begin
        // count strobes that point toward the other alarm state
        if (alarm_nxt != mm_alarm)          cnt_q <= '0;
        else if (mm_defect != mm_alarm)     cnt_q <= cnt_q + 1'b1;
        else                                cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/k2_mode_monitor.sv
module k2_mode_monitor
  import k2mm_pkg::*;
#(
  parameter int REPEAT       = 3,
  parameter int RAISE_FRAMES = 20000,
  parameter int CLEAR_FRAMES = 80000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_tick,
  input  logic [7:0] k2_rx,
  input  logic       cfg_bidir,
  output logic       mm_defect,
  output logic       mm_alarm,
  output logic       eff_bidir
);
  logic            acc_stb;
  logic [K2_W-1:0] acc_k2;
  far_mode_t       far_mode;
  logic            mismatch;
  logic            arch_1n;
  logic            far_unidir;

  k2_accept_filter #(.W(K2_W), .REPEAT(REPEAT)) u_filt (
    .clk(clk), .rst(rst), .frame_tick(frame_tick), .k2_in(k2_rx),
    .acc_stb(acc_stb), .acc_k2(acc_k2)
  );

  k2_far_mode_decode u_dec (
    .clk(clk), .rst(rst), .acc_stb(acc_stb), .acc_k2(acc_k2),
    .cfg_bidir(cfg_bidir), .far_mode(far_mode), .mismatch(mismatch)
  );

  assign arch_1n    = far_mode.arch_1n;
  assign far_unidir = far_mode.far_unidir;

  mm_alarm_integrator #(.RAISE_FRAMES(RAISE_FRAMES), .CLEAR_FRAMES(CLEAR_FRAMES)) u_int (
    .clk(clk), .rst(rst), .frame_tick(frame_tick), .mismatch(mismatch),
    .cfg_bidir(cfg_bidir), .mm_defect(mm_defect), .mm_alarm(mm_alarm),
    .eff_bidir(eff_bidir)
  );
endmodule

// File: rtl/k2mm_checker.sv
module k2mm_checker #(
  parameter int REPEAT = 3
) (
  input logic       clk,
  input logic       rst,
  input logic       frame_tick,
  input logic [7:0] k2_rx,
  input logic       cfg_bidir,
  input logic       mm_defect,
  input logic       mm_alarm,
  input logic       eff_bidir,
  input logic       acc_stb,
  input logic [7:0] acc_k2,
  input logic       arch_1n,
  input logic       far_unidir
);
  logic [7:0]  seen_q;
  logic [15:0] same_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= '0;
      same_q <= '0;
    end else if (frame_tick) begin
      seen_q <= k2_rx;
      if (k2_rx != seen_q)      same_q <= '0;
      else if (same_q != '1)    same_q <= same_q + 1'b1;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mm_alarm && !mm_defect));

  p_accept_on_frame_r2: assert property (@(posedge clk) disable iff (rst)
    acc_stb |-> ($past(frame_tick) && acc_k2 == $past(k2_rx)));

  p_accept_after_run_r2: assert property (@(posedge clk) disable iff (rst)
    acc_stb |-> (32'(same_q) >= REPEAT - 1));

  p_defect_latency_r3: assert property (@(posedge clk) disable iff (rst)
    (acc_stb && (acc_k2[2:0] == 3'b100 || acc_k2[2:0] == 3'b101) &&
     (acc_k2[3] || (cfg_bidir && acc_k2[2:0] == 3'b100))) |-> ##2 mm_defect);

  p_hold_other_code_r5: assert property (@(posedge clk) disable iff (rst)
    (acc_stb && acc_k2[2:0] != 3'b100 && acc_k2[2:0] != 3'b101)
      |=> ($stable(arch_1n) && $stable(far_unidir)));

  p_raise_needs_defect_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(mm_alarm) |-> $past(mm_defect));

  p_clear_needs_clean_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(mm_alarm) |-> !$past(mm_defect));

  p_alarm_forces_unidir_r8: assert property (@(posedge clk) disable iff (rst)
    mm_alarm |-> !eff_bidir);

  p_idle_follows_cfg_r8: assert property (@(posedge clk) disable iff (rst)
    (!mm_alarm && !$past(mm_alarm) && $stable(cfg_bidir)) |-> (eff_bidir == cfg_bidir));

  p_alarm_on_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    (mm_alarm != $past(mm_alarm)) |-> $past(frame_tick));
endmodule

bind k2_mode_monitor k2mm_checker #(.REPEAT(REPEAT)) u_chk (
  .clk(clk), .rst(rst), .frame_tick(frame_tick), .k2_rx(k2_rx),
  .cfg_bidir(cfg_bidir), .mm_defect(mm_defect), .mm_alarm(mm_alarm),
  .eff_bidir(eff_bidir), .acc_stb(acc_stb), .acc_k2(acc_k2),
  .arch_1n(arch_1n), .far_unidir(far_unidir)
);

// File: tb/tb_k2_mode_monitor.sv
`timescale 1ns/100ps
module tb_k2_mode_monitor;
  localparam int RAISE = 20;
  localparam int CLEAR = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_tick = 1'b0;
  logic [7:0] k2_rx = 8'h00;
  logic       cfg_bidir = 1'b1;
  logic       mm_defect, mm_alarm, eff_bidir;

  typedef struct {
    string tag;
    bit    d;
    bit    a;
    bit    e;
  } exp_t;

  exp_t sb[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 1'b0;

  always #2.5 clk = ~clk;

  k2_mode_monitor #(.REPEAT(3), .RAISE_FRAMES(RAISE), .CLEAR_FRAMES(CLEAR)) dut (
    .clk(clk), .rst(rst), .frame_tick(frame_tick), .k2_rx(k2_rx),
    .cfg_bidir(cfg_bidir), .mm_defect(mm_defect), .mm_alarm(mm_alarm),
    .eff_bidir(eff_bidir)
  );

  task automatic expect_out(input string tag, input bit d, input bit a, input bit e);
    exp_t it;
    it.tag = tag; it.d = d; it.a = a; it.e = e;
    sb.push_back(it);
  endtask

  task automatic send(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      k2_rx = v;
      frame_tick = 1'b1;
      @(negedge clk);
      frame_tick = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic set_cfg(input logic v);
    @(negedge clk);
    cfg_bidir = v;
    repeat (3) @(negedge clk);
  endtask

  // monitor: compares outputs with the oldest expected item
  initial begin
    forever begin
      exp_t it;
      wait (sb.size() != 0);
      it = sb.pop_front();
      n_checks++;
      if ({mm_defect, mm_alarm, eff_bidir} !== {it.d, it.a, it.e}) begin
        n_fail++;
        $display("FAIL %s: defect/alarm/eff actual %b%b%b expected %b%b%b",
                 it.tag, mm_defect, mm_alarm, eff_bidir, it.d, it.a, it.e);
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    expect_out("R1 reset state", 0, 0, 1);

    send(8'h05, 3);  expect_out("R3 clean 1+1 bidir", 0, 0, 1);
    send(8'h0D, 2);  expect_out("R2 two frames not accepted", 0, 0, 1);
    send(8'h0D, 1);  expect_out("R3 1:N after third frame", 1, 0, 1);
    for (int i = 0; i < 4; i++) begin
      send(8'h05, 1);
      send(8'h0D, 1);
    end
    expect_out("R2 inconsistent bytes ignored", 1, 0, 1);
    send(8'h05, 3);  expect_out("R3 back to bidir", 0, 0, 1);
    send(8'h04, 3);  expect_out("R3 unidirectional far end", 1, 0, 1);
    send(8'h05, 3);  expect_out("R3 clear unidir", 0, 0, 1);

    set_cfg(1'b0);
    send(8'h04, 3);  expect_out("R4 unidir with cfg unidir", 0, 0, 0);
    send(8'h0C, 3);  expect_out("R4 1:N with cfg unidir", 1, 0, 0);
    send(8'h05, 3);  expect_out("R4 clean with cfg unidir", 0, 0, 0);
    set_cfg(1'b1);
    expect_out("R1 eff follows cfg", 0, 0, 1);

    // interrupted raise run
    send(8'h0D, 3);  expect_out("R3 1:N again", 1, 0, 1);
    send(8'h06, 15); expect_out("R5 other code holds defect", 1, 0, 1);
    send(8'h05, 4);  expect_out("R6 run interrupted", 0, 0, 1);

    // raise boundary
    send(8'h0D, 3);
    send(8'h06, 19); expect_out("R6 one strobe before raise", 1, 0, 1);
    send(8'h06, 1);  expect_out("R6 alarm raised / R8 eff unidir", 1, 1, 0);
    send(8'h06, 50); expect_out("R5 no clearing without bidir code", 1, 1, 0);

    // interrupted clear run
    send(8'h05, 3);  expect_out("R7 defect gone alarm held", 0, 1, 0);
    send(8'h05, 30); expect_out("R7 clearing in progress", 0, 1, 0);
    send(8'h0D, 3);  expect_out("R7 defect returns", 1, 1, 0);
    send(8'h05, 3);  expect_out("R7 countdown restarts", 0, 1, 0);
    send(8'h05, 39); expect_out("R7 one strobe before clear", 0, 1, 0);
    send(8'h05, 1);  expect_out("R7 alarm cleared / R8 eff bidir", 0, 0, 1);

    // no strobes: nothing advances
    repeat (200) @(negedge clk);
    expect_out("R9 idle without strobes", 0, 0, 1);

    wait (sb.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule